// File: doc/BRIEF.md
# Base-Limit Address Relocation and Protection Unit

This unit sits on the path from a processor's address port to memory and binds addresses at execution time for a single contiguous partition. Each accepted request carries a logical address, a read/write command, write data and the current privilege mode. In user mode the logical address is compared against a limit register and, when it is in range, a relocation base is added to form the physical address sent to memory; an out-of-range access never reaches memory and instead raises a one-cycle trap, with the offending logical address captured for the kernel to read. In kernel mode the address passes through untranslated and unchecked.

The base and limit registers are loaded through a separate register-write port that only takes effect in kernel mode; a user-mode attempt is discarded and raises a privilege trap. The unit adds exactly one register stage between an accepted request and the memory-side command.

Top module: `reloc_guard`

## Requirements
- R1: While reset is held and on the first cycle after it, memValid and trapValid are 0 and curBase, curLimit and faultAddr are 0; from the second cycle after reset release reqReady is 1 and stays 1.
- R2: A request accepted (reqValid and reqReady high at a rising edge) in user mode (kernelMode = 0) with reqAddr < curLimit drives memValid high on the cycle after acceptance, with memAddr = (curBase + reqAddr) modulo 2^PA_W, and memWrite and memWdata equal to the request's reqWrite and reqWdata.
- R3: A request accepted in user mode with reqAddr >= curLimit leaves memValid low on the following cycle and instead raises trapValid with trapCause bit 0 set, and faultAddr then holds the request's reqAddr.
- R4: A request accepted in kernel mode (kernelMode = 1) drives memValid on the following cycle with memAddr equal to reqAddr zero-extended to PA_W bits, whatever curBase and curLimit hold (including limit 0), and raises no trap.
- R5: A register write (regWrEn = 1) in kernel mode loads curBase from regWrData when regSel = 0, or loads curLimit from the low LA_W+1 bits of regWrData when regSel = 1; the new value is visible on the cycle after the write.
- R6: A register write in user mode changes neither curBase nor curLimit, leaves faultAddr unchanged, and raises trapValid with trapCause bit 1 set on the following cycle.
- R7: trapValid is high only on the cycle directly after an offending event; with no new offending event it returns to 0 on the next cycle.
- R8: The limit register is LA_W+1 bits wide, so a limit of 2^LA_W makes every logical address legal in user mode.
- R9: When a user-mode out-of-range access and a user-mode register write occur in the same cycle, a single trap is raised with trapCause = 2'b11.
- R10: Relocation wraps: when curBase + reqAddr exceeds 2^PA_W - 1 the physical address is the sum truncated to PA_W bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Access request present |
| reqReady | output | 1 | Unit can accept a request |
| reqAddr | input | LA_W | Logical address |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqWdata | input | DATA_W | Write data |
| kernelMode | input | 1 | Privilege of the current request and register write (1 = kernel) |
| regWrEn | input | 1 | Register write strobe |
| regSel | input | 1 | 0 = relocation base, 1 = limit |
| regWrData | input | PA_W | Value to load |
| memValid | output | 1 | Memory command valid |
| memAddr | output | PA_W | Physical address |
| memWrite | output | 1 | Memory command is a write |
| memWdata | output | DATA_W | Memory write data |
| trapValid | output | 1 | One-cycle trap pulse |
| trapCause | output | 2 | Bit 0 out of bounds, bit 1 privilege violation |
| faultAddr | output | LA_W | Logical address of the last out-of-bounds access |
| curBase | output | PA_W | Current relocation base |
| curLimit | output | LA_W+1 | Current limit |

## Verification
Every logical address is swept back to back in user mode under several base/limit settings: a mid-range window, a limit of one (only address 0 legal), the reset limit of zero (everything traps), and a full-span limit with a base near the top of the physical range. The mid-range and one-entry windows locate the strict less-than boundary exactly, the zero limit separates trap from pass-through, and the full-span case with a high base exposes missing wraparound or a narrowed limit register. A kernel-mode sweep under limit zero and a non-zero base tells apart correct bypass from translation or checking leaking into kernel mode, and user-mode register writes, alone and together with a bad access, show the registers stay put and the cause bits combine.

// File: rtl/reloc_pkg.sv
package reloc_pkg;

  // Strobes from control to datapath, valid for the current cycle only.
  typedef struct packed {
    logic issue;      // accepted access goes to memory
    logic boundTrap;  // accepted user access is out of range
    logic privTrap;   // register write attempted from user mode
    logic loadBase;   // privileged load of the relocation base
    logic loadLimit;  // privileged load of the limit
    logic translate;  // add the base to the outgoing address
  } relocStrobe_t;

  localparam int CauseBound = 0;
  localparam int CausePriv  = 1;

endpackage

// File: rtl/reloc_ctrl.sv
module reloc_ctrl
  import reloc_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         reqValid,
  input  logic         kernelMode,
  input  logic         regWrEn,
  input  logic         regSel,
  input  logic         inBounds,
  output logic         reqReady,
  output relocStrobe_t strobe
);

  logic readyQ;
  logic accept;

  always_ff @(posedge clk) begin
    if (!rstN) readyQ <= 1'b0;
    else       readyQ <= 1'b1;
  end

  assign reqReady = readyQ;
  assign accept   = reqValid && readyQ;

  always_comb begin
    strobe           = '0;
    strobe.translate = !kernelMode;
    strobe.issue     = accept && (kernelMode || inBounds);
    strobe.boundTrap = accept && !kernelMode && !inBounds;
    strobe.privTrap  = regWrEn && !kernelMode;
    strobe.loadBase  = regWrEn && kernelMode && !regSel;
    strobe.loadLimit = regWrEn && kernelMode && regSel;
  end

  // R5/R6: a register load and a privilege trap never coincide
  a_r6_load_excludes_trap: assert property (@(posedge clk) disable iff (!rstN)
    !((strobe.loadBase || strobe.loadLimit) && strobe.privTrap));

  // R3: an access is either issued or trapped, never both
  a_r3_issue_or_trap: assert property (@(posedge clk) disable iff (!rstN)
    !(strobe.issue && strobe.boundTrap));

endmodule

// File: rtl/reloc_dp.sv
module reloc_dp
  import reloc_pkg::*;
#(
  parameter int LA_W   = 8,
  parameter int PA_W   = 10,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  relocStrobe_t      strobe,
  input  logic [LA_W-1:0]   reqAddr,
  input  logic              reqWrite,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic [PA_W-1:0]   regWrData,
  output logic              inBounds,
  output logic              memValid,
  output logic [PA_W-1:0]   memAddr,
  output logic              memWrite,
  output logic [DATA_W-1:0] memWdata,
  output logic              trapValid,
  output logic [1:0]        trapCause,
  output logic [LA_W-1:0]   faultAddr,
  output logic [PA_W-1:0]   curBase,
  output logic [LA_W:0]     curLimit
);

  localparam int LIM_W = LA_W + 1;

  logic [PA_W-1:0]   baseQ;
  logic [LIM_W-1:0]  limitQ;
  logic [PA_W-1:0]   physNext;
  logic              memValidQ;
  logic [PA_W-1:0]   memAddrQ;
  logic              memWriteQ;
  logic [DATA_W-1:0] memWdataQ;
  logic              trapQ;
  logic [1:0]        causeQ;
  logic [LA_W-1:0]   faultQ;

  assign inBounds = {1'b0, reqAddr} < limitQ;
  assign physNext = strobe.translate ? (baseQ + PA_W'(reqAddr)) : PA_W'(reqAddr);

  // Relocation and limit registers
  always_ff @(posedge clk) begin
    if (!rstN) begin
      baseQ  <= '0;
      limitQ <= '0;
    end else begin
      if (strobe.loadBase)  baseQ  <= regWrData;
      if (strobe.loadLimit) limitQ <= regWrData[LIM_W-1:0];
    end
  end

  // Memory-side command stage
  always_ff @(posedge clk) begin
    if (!rstN) begin
      memValidQ <= 1'b0;
      memAddrQ  <= '0;
      memWriteQ <= 1'b0;
      memWdataQ <= '0;
    end else begin
      memValidQ <= strobe.issue;
      if (strobe.issue) begin
        memAddrQ  <= physNext;
        memWriteQ <= reqWrite;
        memWdataQ <= reqWdata;
      end
    end
  end

  // Trap pulse and fault capture
  always_ff @(posedge clk) begin
    if (!rstN) begin
      trapQ  <= 1'b0;
      causeQ <= '0;
      faultQ <= '0;
    end else begin
      trapQ             <= strobe.boundTrap || strobe.privTrap;
      causeQ[CauseBound] <= strobe.boundTrap;
      causeQ[CausePriv]  <= strobe.privTrap;
      if (strobe.boundTrap) faultQ <= reqAddr;
    end
  end

  assign memValid  = memValidQ;
  assign memAddr   = memAddrQ;
  assign memWrite  = memWriteQ;
  assign memWdata  = memWdataQ;
  assign trapValid = trapQ;
  assign trapCause = causeQ;
  assign faultAddr = faultQ;
  assign curBase   = baseQ;
  assign curLimit  = limitQ;

  // R3: an out-of-bounds trap never coincides with a memory command
  a_r3_bound_blocks_mem: assert property (@(posedge clk) disable iff (!rstN)
    trapCause[CauseBound] |-> !memValid);

  // R7: a trap pulse always carries a cause, and causes only appear with a pulse
  a_r7_cause_with_pulse: assert property (@(posedge clk) disable iff (!rstN)
    trapValid == (trapCause != 2'b00));

endmodule

// File: rtl/reloc_guard.sv
module reloc_guard
  import reloc_pkg::*;
#(
  parameter int LA_W   = 8,
  parameter int PA_W   = 10,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic [LA_W-1:0]   reqAddr,
  input  logic              reqWrite,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic              kernelMode,
  input  logic              regWrEn,
  input  logic              regSel,
  input  logic [PA_W-1:0]   regWrData,
  output logic              memValid,
  output logic [PA_W-1:0]   memAddr,
  output logic              memWrite,
  output logic [DATA_W-1:0] memWdata,
  output logic              trapValid,
  output logic [1:0]        trapCause,
  output logic [LA_W-1:0]   faultAddr,
  output logic [PA_W-1:0]   curBase,
  output logic [LA_W:0]     curLimit
);

  relocStrobe_t strobe;
  logic         inBounds;

  reloc_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .reqValid   (reqValid),
    .kernelMode (kernelMode),
    .regWrEn    (regWrEn),
    .regSel     (regSel),
    .inBounds   (inBounds),
    .reqReady   (reqReady),
    .strobe     (strobe)
  );

  reloc_dp #(
    .LA_W   (LA_W),
    .PA_W   (PA_W),
    .DATA_W (DATA_W)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .reqAddr   (reqAddr),
    .reqWrite  (reqWrite),
    .reqWdata  (reqWdata),
    .regWrData (regWrData),
    .inBounds  (inBounds),
    .memValid  (memValid),
    .memAddr   (memAddr),
    .memWrite  (memWrite),
    .memWdata  (memWdata),
    .trapValid (trapValid),
    .trapCause (trapCause),
    .faultAddr (faultAddr),
    .curBase   (curBase),
    .curLimit  (curLimit)
  );

  // R4: kernel accesses reach memory untranslated one cycle later
  a_r4_kernel_bypass: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady && kernelMode) |=>
      (memValid && !trapCause[CauseBound] && memAddr == PA_W'($past(reqAddr))));

  // R2/R10: legal user accesses are relocated with wraparound
  a_r2_user_relocate: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady && !kernelMode && ({1'b0, reqAddr} < curLimit)) |=>
      (memValid && memAddr == PA_W'($past(curBase) + PA_W'($past(reqAddr)))));

  // R3: illegal user accesses trap and capture the address
  a_r3_user_trap: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady && !kernelMode && ({1'b0, reqAddr} >= curLimit)) |=>
      (!memValid && trapValid && trapCause[CauseBound] && faultAddr == $past(reqAddr)));

  // R6: user-mode register writes leave both registers untouched
  a_r6_priv_write_ignored: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && !kernelMode) |=>
      ($stable(curBase) && $stable(curLimit) && trapCause[CausePriv]));

endmodule

// File: tb/sim_reloc_guard.sv
module sim_reloc_guard;

  localparam int LA_W   = 8;
  localparam int PA_W   = 10;
  localparam int DATA_W = 8;
  localparam int NADDR  = 1 << LA_W;
  localparam int PMASK  = (1 << PA_W) - 1;

  logic              clk = 1'b0;
  logic              rstN;
  logic              reqValid;
  logic              reqReady;
  logic [LA_W-1:0]   reqAddr;
  logic              reqWrite;
  logic [DATA_W-1:0] reqWdata;
  logic              kernelMode;
  logic              regWrEn;
  logic              regSel;
  logic [PA_W-1:0]   regWrData;
  logic              memValid;
  logic [PA_W-1:0]   memAddr;
  logic              memWrite;
  logic [DATA_W-1:0] memWdata;
  logic              trapValid;
  logic [1:0]        trapCause;
  logic [LA_W-1:0]   faultAddr;
  logic [PA_W-1:0]   curBase;
  logic [LA_W:0]     curLimit;

  int checks = 0;
  int errors = 0;
  int mBase  = 0;
  int mLimit = 0;
  int mFault = 0;

  always #4 clk = ~clk;

  reloc_guard #(.LA_W(LA_W), .PA_W(PA_W), .DATA_W(DATA_W)) u0 (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqAddr(reqAddr), .reqWrite(reqWrite), .reqWdata(reqWdata),
    .kernelMode(kernelMode), .regWrEn(regWrEn), .regSel(regSel),
    .regWrData(regWrData), .memValid(memValid), .memAddr(memAddr),
    .memWrite(memWrite), .memWdata(memWdata), .trapValid(trapValid),
    .trapCause(trapCause), .faultAddr(faultAddr), .curBase(curBase),
    .curLimit(curLimit)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic idleInputs();
    reqValid = 1'b0; reqAddr = '0; reqWrite = 1'b0; reqWdata = '0;
    kernelMode = 1'b0; regWrEn = 1'b0; regSel = 1'b0; regWrData = '0;
  endtask

  // Kernel register write; called just after a falling edge.
  task automatic kwrite(input bit sel, input int val);
    regWrEn = 1'b1; regSel = sel; regWrData = PA_W'(val); kernelMode = 1'b1;
    @(negedge clk);
    idleInputs();
    if (sel) mLimit = val & ((1 << (LA_W + 1)) - 1);
    else     mBase  = val & PMASK;
    chk(int'(curBase) == mBase, "R5 base", int'(curBase), mBase);
    chk(int'(curLimit) == mLimit, "R5 limit", int'(curLimit), mLimit);
    chk(!trapValid, "R5 no trap", int'(trapValid), 0);
  endtask

  // One access; called just after a falling edge, checks one cycle later.
  task automatic access(input int a, input bit kern);
    bit legal;
    int expAddr;
    reqValid = 1'b1; reqAddr = LA_W'(a); kernelMode = kern;
    reqWrite = a[0]; reqWdata = DATA_W'(a ^ 8'h5A);
    @(negedge clk);
    legal   = kern || (a < mLimit);
    expAddr = kern ? a : ((mBase + a) & PMASK);
    if (legal) begin
      chk(memValid && !trapValid, kern ? "R4 issue" : "R2 issue", int'(memValid), 1);
      chk(int'(memAddr) == expAddr, kern ? "R4 addr" : "R2 addr", int'(memAddr), expAddr);
      chk(memWrite == a[0] && int'(memWdata) == ((a ^ 8'h5A) & 8'hFF),
          "R2 cmd", int'(memWdata), (a ^ 8'h5A) & 8'hFF);
    end else begin
      mFault = a;
      chk(!memValid, "R3 blocked", int'(memValid), 0);
      chk(trapValid && trapCause == 2'b01, "R3 trap", int'(trapCause), 1);
      chk(int'(faultAddr) == a, "R3 fault", int'(faultAddr), a);
    end
  endtask

  task automatic userSweep();
    for (int a = 0; a < NADDR; a++) access(a, 1'b0);
    idleInputs();
    @(negedge clk);
    chk(!trapValid && !memValid, "R7 idle after sweep", int'(trapValid), 0);
  endtask

  initial begin
    #(8 * 150000);
    errors++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    idleInputs();
    rstN = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(!memValid && !trapValid, "R1 outputs in reset", int'(memValid), 0);
    chk(curBase == 0 && curLimit == 0 && faultAddr == 0, "R1 regs in reset", int'(curBase), 0);
    rstN = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk(reqReady, "R1 ready", int'(reqReady), 1);

    // Reset limit 0: every user access traps
    userSweep();

    // Kernel sweep under limit 0 with a non-zero base: untranslated, unchecked
    kwrite(1'b0, 10'h155);
    for (int a = 0; a < NADDR; a++) access(a, 1'b1);
    idleInputs();

    // Mid-range window
    kwrite(1'b1, 9'h040);
    kwrite(1'b0, 10'h100);
    userSweep();

    // One-entry window
    kwrite(1'b1, 1);
    kwrite(1'b0, 10'h025);
    userSweep();

    // R8/R10: full-span limit, base near the top of physical space
    kwrite(1'b1, 9'h100);
    kwrite(1'b0, 10'h3F0);
    userSweep();

    // R6: user register writes ignored and trapped
    for (int s = 0; s < 2; s++) begin
      regWrEn = 1'b1; regSel = s[0]; regWrData = 10'h2AA; kernelMode = 1'b0;
      @(negedge clk);
      idleInputs();
      chk(int'(curBase) == mBase && int'(curLimit) == mLimit, "R6 regs kept",
          int'(curBase), mBase);
      chk(trapValid && trapCause == 2'b10, "R6 priv trap", int'(trapCause), 2);
      chk(int'(faultAddr) == mFault, "R6 fault kept", int'(faultAddr), mFault);
      @(negedge clk);
      chk(!trapValid, "R7 pulse ends", int'(trapValid), 0);
    end

    // R9: bad user access plus user register write in the same cycle
    kwrite(1'b1, 9'h010);
    reqValid = 1'b1; reqAddr = 8'h80; regWrEn = 1'b1; regSel = 1'b1;
    regWrData = 10'h1FF; kernelMode = 1'b0;
    @(negedge clk);
    idleInputs();
    chk(trapValid && trapCause == 2'b11, "R9 combined cause", int'(trapCause), 3);
    chk(!memValid && faultAddr == 8'h80, "R9 fault", int'(faultAddr), 8'h80);
    chk(int'(curLimit) == 16, "R9 limit kept", int'(curLimit), 16);
    @(negedge clk);
    chk(!trapValid && trapCause == 2'b00, "R7 single pulse", int'(trapValid), 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule